// File: doc/BRIEF.md
# Pulse-Width Modulator Channel with Buffered Reload

This block is a single pulse-width modulation channel meant to sit beside its siblings under a shared control bank. Each clock cycle it receives a vector of clock-enable strobes: eleven power-of-two prescaler outputs and two linear-divider outputs. It uses one of them to advance its counter. It has its own enable bit and a small register window with mode, duty, period, a read-only counter and a reload register.

The counter runs from zero up to the period value and then wraps. In center mode it climbs to the period and falls back to zero, which gives a symmetric pulse that is twice as long. The waveform is at the active level while the counter is below the duty value, and at the idle level otherwise. The idle level is chosen by a mode bit. The reload register lets software change either period or duty while the channel runs. The new value stays pending until the next period boundary, and a one-cycle event pulse marks that boundary.

Top module: `pwm_chan`

## Requirements
- R1: After reset, every register reads zero, the waveform is low and the event output is low.
- R2: Mode bits 3:0 pick the counting strobe. Codes 0 to 10 use strobe bit 0 to 10 of `tick_i`, code 11 uses bit 11 (divider A) and code 12 uses bit 12 (divider B). Codes 13 to 15 stop the counter.
- R3: With mode bit 8 clear, each selected strobe adds one to the counter. A strobe that finds the counter at or above the period sets it to zero. Events are therefore period+1 strobes apart.
- R4: With mode bit 8 set, the counter rises to the period and then falls. The strobe that brings it back to zero is the boundary. Events are therefore 2×period strobes apart.
- R5: When enabled, the waveform is the inverse of mode bit 9 while counter < duty, and equal to mode bit 9 otherwise.
- R6: While `en_i` is low, the counter is zero, the waveform equals mode bit 9 and no event fires. Enabling therefore starts from zero.
- R7: A write to the reload register (word 4) is held pending. At the next boundary it replaces the duty (mode bit 10 clear) or the period (bit 10 set). Until then the duty and period read back unchanged.
- R8: The counter (word 3) is read-only, and a write to it has no effect.
- R9: With a period of zero and a duty of zero, every selected strobe is a boundary and the waveform stays idle.
- R10: `evt_o` is high for exactly one cycle, in the cycle after each boundary strobe. Period, duty and reload writes hit word indices 2, 1 and 4, and the mode is at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 13 | Clock-enable strobes: prescaler 0..10, divider A, divider B |
| en_i | input | 1 | Channel enable from the control bank |
| reg_wr_i | input | 1 | Register write strobe |
| reg_idx_i | input | 3 | Word index (byte offset / 4) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_idx_i` (combinational) |
| wave_o | output | 1 | Modulated waveform |
| evt_o | output | 1 | One-cycle period-boundary pulse |

## Verification
The assertions check several properties on every cycle:
- the counter holds at zero while the channel is disabled;
- the counter is frozen on cycles without a selected strobe;
- the left-mode wrap and the center-mode down-step are correct;
- every event follows an enabled strobe;
- a pending reload is cleared at a boundary;
- duty never changes without a write or a transfer.

Other behaviour needs whole sequences and is shown only by the bench's scenarios. This covers the exact spacing of events in each mode, the waveform level against the duty value, the deferred visibility of reload values, and the effect of each strobe source. A cycle-accurate reference model compares these against the block on every clock.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
   localparam int unsigned N_PRESCALE = 11;
   localparam int unsigned N_TICK     = N_PRESCALE + 2;
   localparam int unsigned SRC_DIV_A  = N_PRESCALE;
   localparam int unsigned SRC_DIV_B  = N_PRESCALE + 1;

   localparam logic [2:0] IDX_MODE   = 3'd0;
   localparam logic [2:0] IDX_DUTY   = 3'd1;
   localparam logic [2:0] IDX_PERIOD = 3'd2;
   localparam logic [2:0] IDX_COUNT  = 3'd3;
   localparam logic [2:0] IDX_RELOAD = 3'd4;

   typedef struct packed {
      logic       reload_per;
      logic       idle_hi;
      logic       center;
      logic [3:0] src;
   } mode_t;
endpackage

// File: rtl/pwm_chan_tick_sel.sv
module pwm_chan_tick_sel
   import pwm_chan_pkg::*;
#(
   parameter int unsigned NT = N_TICK
) (
   input  logic [NT-1:0] tick_i,
   input  logic [3:0]    src_i,
   output logic          tick_o
);
   logic [NT-1:0] hit;

   generate
      if (NT > 16) begin : g_bad_nt
         $error("pwm_chan_tick_sel: more strobes than a 4-bit code can reach");
      end
      for (genvar k = 0; k < NT; k++) begin : g_match
         assign hit[k] = tick_i[k] && (src_i == 4'(k));
      end
   endgenerate

   assign tick_o = |hit;
endmodule

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
   import pwm_chan_pkg::*;
#(
   parameter int unsigned CNT_W  = 20,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [2:0]        idx_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              xfer_i,
   output mode_t             mode_o,
   output logic [CNT_W-1:0]  duty_o,
   output logic [CNT_W-1:0]  per_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int unsigned PAD_W = DATA_W - CNT_W;

   mode_t            mode_q;
   logic [CNT_W-1:0] duty_q, per_q, rld_q;
   logic             pend_q;
   logic             wr_mode, wr_duty, wr_per, wr_rld;

   assign wr_mode = wr_i && (idx_i == IDX_MODE);
   assign wr_duty = wr_i && (idx_i == IDX_DUTY);
   assign wr_per  = wr_i && (idx_i == IDX_PERIOD);
   assign wr_rld  = wr_i && (idx_i == IDX_RELOAD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         duty_q <= '0;
         per_q  <= '0;
         rld_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         if (wr_mode) begin
            mode_q.src        <= wdata_i[3:0];
            mode_q.center     <= wdata_i[8];
            mode_q.idle_hi    <= wdata_i[9];
            mode_q.reload_per <= wdata_i[10];
         end
         if (wr_duty)
            duty_q <= wdata_i[CNT_W-1:0];
         else if (xfer_i && pend_q && !mode_q.reload_per)
            duty_q <= rld_q;
         if (wr_per)
            per_q <= wdata_i[CNT_W-1:0];
         else if (xfer_i && pend_q && mode_q.reload_per)
            per_q <= rld_q;
         if (wr_rld) begin
            rld_q  <= wdata_i[CNT_W-1:0];
            pend_q <= 1'b1;
         end else if (xfer_i) begin
            pend_q <= 1'b0;
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      unique case (idx_i)
         IDX_MODE: begin
            rdata_o[3:0] = mode_q.src;
            rdata_o[8]   = mode_q.center;
            rdata_o[9]   = mode_q.idle_hi;
            rdata_o[10]  = mode_q.reload_per;
         end
         IDX_DUTY:   rdata_o = {{PAD_W{1'b0}}, duty_q};
         IDX_PERIOD: rdata_o = {{PAD_W{1'b0}}, per_q};
         IDX_COUNT:  rdata_o = {{PAD_W{1'b0}}, cnt_i};
         IDX_RELOAD: rdata_o = {{PAD_W{1'b0}}, rld_q};
         default:    rdata_o = '0;
      endcase
   end

   assign mode_o = mode_q;
   assign duty_o = duty_q;
   assign per_o  = per_q;

   // R7: a pending reload is consumed at a boundary unless re-armed
   a_r7_pend_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && xfer_i && !wr_rld) |=> !pend_q);
   // R7: duty moves only by a write or a reload transfer
   a_r7_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_duty && !xfer_i) |=> $stable(duty_q));
   // R7: period likewise
   a_r7_per_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_per && !xfer_i) |=> $stable(per_q));
endmodule

// File: rtl/pwm_chan_cnt.sv
module pwm_chan_cnt #(
   parameter int unsigned CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             tick_i,
   input  logic             center_i,
   input  logic             idle_hi_i,
   input  logic [CNT_W-1:0] per_i,
   input  logic [CNT_W-1:0] duty_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o,
   output logic             evt_o,
   output logic             wave_o
);
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             down_q, down_d, wrap, evt_q;

   always_comb begin
      cnt_d  = cnt_q;
      down_d = down_q;
      wrap   = 1'b0;
      if (!en_i) begin
         cnt_d  = '0;
         down_d = 1'b0;
      end else if (tick_i) begin
         if (!center_i) begin
            down_d = 1'b0;
            if (cnt_q >= per_i) begin
               cnt_d = '0;
               wrap  = 1'b1;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end else if (!down_q) begin
            if (cnt_q < per_i) begin
               cnt_d = cnt_q + 1'b1;
            end else if (cnt_q == '0) begin
               wrap = 1'b1;
            end else if (cnt_q == CNT_W'(1)) begin
               cnt_d = '0;
               wrap  = 1'b1;
            end else begin
               cnt_d  = cnt_q - 1'b1;
               down_d = 1'b1;
            end
         end else begin
            if (cnt_q <= CNT_W'(1)) begin
               cnt_d  = '0;
               down_d = 1'b0;
               wrap   = 1'b1;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         down_q <= 1'b0;
         evt_q  <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         down_q <= down_d;
         evt_q  <= wrap;
      end
   end

   assign cnt_o  = cnt_q;
   assign wrap_o = wrap;
   assign evt_o  = evt_q;
   assign wave_o = (en_i && (cnt_q < duty_i)) ? !idle_hi_i : idle_hi_i;

   // R6: a disabled channel holds its counter at zero
   a_r6_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (cnt_q == '0));
   // R2: no selected strobe, no movement
   a_r2_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !tick_i) |=> $stable(cnt_q));
   // R3: left mode wraps to zero at the period
   a_r3_left_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && tick_i && !center_i && cnt_q >= per_i) |=> (cnt_q == '0));
   // R4: center mode steps down by one while falling
   a_r4_center_down: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && tick_i && center_i && down_q && cnt_q > CNT_W'(1))
      |=> (cnt_q == $past(cnt_q) - 1'b1));
   // R10: every event follows an enabled strobe
   a_r10_evt_cause: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q |-> $past(en_i && tick_i));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
   import pwm_chan_pkg::*;
#(
   parameter int unsigned CNT_W  = 20,
   parameter int unsigned DATA_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_TICK-1:0]  tick_i,
   input  logic               en_i,
   input  logic               reg_wr_i,
   input  logic [2:0]         reg_idx_i,
   input  logic [DATA_W-1:0]  reg_wdata_i,
   output logic [DATA_W-1:0]  reg_rdata_o,
   output logic               wave_o,
   output logic               evt_o
);
   generate
      if (CNT_W < 16 || CNT_W > DATA_W) begin : g_bad_width
         $error("pwm_chan: CNT_W must lie between 16 and DATA_W");
      end
      if (DATA_W < 11) begin : g_bad_data
         $error("pwm_chan: DATA_W too narrow for the mode fields");
      end
   endgenerate

   mode_t            mode;
   logic [CNT_W-1:0] duty, per, cnt;
   logic             tick_sel, wrap;

   pwm_chan_tick_sel #(.NT(N_TICK)) u_sel (
      .tick_i (tick_i),
      .src_i  (mode.src),
      .tick_o (tick_sel)
   );

   pwm_chan_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (reg_wr_i),
      .idx_i   (reg_idx_i),
      .wdata_i (reg_wdata_i),
      .cnt_i   (cnt),
      .xfer_i  (wrap),
      .mode_o  (mode),
      .duty_o  (duty),
      .per_o   (per),
      .rdata_o (reg_rdata_o)
   );

   pwm_chan_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (en_i),
      .tick_i    (tick_sel),
      .center_i  (mode.center),
      .idle_hi_i (mode.idle_hi),
      .per_i     (per),
      .duty_i    (duty),
      .cnt_o     (cnt),
      .wrap_o    (wrap),
      .evt_o     (evt_o),
      .wave_o    (wave_o)
   );
endmodule

// File: tb/pwm_chan_tb_top.sv
`timescale 1ns/1ps
module pwm_chan_tb_top;
   localparam int T = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] tick = '0;
   logic        en = 1'b0;
   logic        wr = 1'b0;
   logic [2:0]  idx = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        wave, evt;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit finished = 0;

   // reference model state
   int m_cnt = 0, m_dir = 1, m_per = 0, m_duty = 0, m_pval = 0, m_src = 0;
   bit m_pend = 0, m_ctr = 0, m_idle = 0, m_rper = 0, m_evt = 0;

   always #(T/2) clk = ~clk;

   pwm_chan dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_i(en),
      .reg_wr_i(wr), .reg_idx_i(idx), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .wave_o(wave), .evt_o(evt)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // strobe pattern: prescaler k every 2^k cycles, A every 3, B every 7
   always @(negedge clk) begin
      cyc++;
      for (int k = 0; k < 11; k++) tick[k] <= ((cyc % (1 << k)) == 0);
      tick[11] <= ((cyc % 3) == 0);
      tick[12] <= ((cyc % 7) == 0);
   end

   // behavioural reference, stepped on each rising edge
   always @(posedge clk) begin
      bit tk, w;
      if (!rst_n) begin
         m_cnt = 0; m_dir = 1; m_per = 0; m_duty = 0; m_pval = 0; m_src = 0;
         m_pend = 0; m_ctr = 0; m_idle = 0; m_rper = 0; m_evt = 0;
      end else begin
         tk = (m_src <= 12) ? tick[m_src] : 1'b0;
         w = 0;
         if (!en) begin
            m_cnt = 0; m_dir = 1;
         end else if (tk) begin
            if (!m_ctr) begin
               m_dir = 1;
               if (m_cnt >= m_per) begin m_cnt = 0; w = 1; end
               else m_cnt++;
            end else if (m_dir > 0) begin
               if (m_cnt < m_per) m_cnt++;
               else if (m_cnt == 0) w = 1;
               else begin
                  m_cnt--; m_dir = -1;
                  if (m_cnt == 0) begin w = 1; m_dir = 1; end
               end
            end else begin
               m_cnt--;
               if (m_cnt <= 0) begin m_cnt = 0; m_dir = 1; w = 1; end
            end
         end
         m_evt = w;
         if (w && m_pend) begin
            if (m_rper) m_per = m_pval; else m_duty = m_pval;
         end
         if (wr && idx == 3'd4) begin m_pend = 1; m_pval = int'(wdata[19:0]); end
         else if (w) m_pend = 0;
         if (wr && idx == 3'd0) begin
            m_src = int'(wdata[3:0]); m_ctr = wdata[8]; m_idle = wdata[9]; m_rper = wdata[10];
         end
         if (wr && idx == 3'd1) m_duty = int'(wdata[19:0]);
         if (wr && idx == 3'd2) m_per = int'(wdata[19:0]);
      end
   end

   // per-cycle comparison in the middle of the high phase
   always @(posedge clk) begin
      #5;
      if (rst_n && !finished) begin
         bit exp_w;
         exp_w = en ? ((m_cnt < m_duty) ? !m_idle : m_idle) : m_idle;
         chk(wave == exp_w, "R5 wave", int'(wave), int'(exp_w));
         chk(evt == m_evt, "R10 evt", int'(evt), int'(m_evt));
      end
   end

   task automatic wreg(input logic [2:0] i, input int v);
      @(negedge clk);
      wr = 1'b1; idx = i; wdata = v;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rreg(input logic [2:0] i, output int v);
      idx = i;
      #1;
      v = int'(rdata);
   endtask

   task automatic wait_evt();
      int n = 0;
      do begin @(posedge clk); #5; n++; end while (!evt && n < 2000);
   endtask

   task automatic gap(output int n);
      n = 0;
      wait_evt();
      do begin @(posedge clk); #5; n++; end while (!evt && n < 2000);
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   initial begin
      #(T * 150000);
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      bad++; total++;
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int v, g, c1, c2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int i = 0; i < 5; i++) begin
         rreg(3'(i), v);
         chk(v == 0, "R1 reg reset", v, 0);
      end
      chk(wave == 1'b0, "R1 wave reset", int'(wave), 0);
      chk(evt == 1'b0, "R1 evt reset", int'(evt), 0);

      // R3 left mode, prescaler code 0: period 4 -> 5 strobes apart
      wreg(3'd2, 4); wreg(3'd1, 2); wreg(3'd0, 0);
      @(negedge clk); en = 1'b1;
      gap(g);
      chk(g == 5, "R3 left spacing", g, 5);
      idle(7);

      // R8 counter write ignored
      @(negedge clk);
      wreg(3'd3, 77);
      rreg(3'd3, v);
      chk(v == m_cnt, "R8 counter read-only", v, m_cnt);

      // R7 reload into duty
      wreg(3'd4, 1);
      rreg(3'd1, v);
      chk(v == 2, "R7 duty deferred", v, 2);
      wait_evt();
      rreg(3'd1, v);
      chk(v == 1, "R7 duty reloaded", v, 1);
      // R7 reload into period (mode bit 10)
      wreg(3'd0, 32'h400);
      wreg(3'd4, 6);
      rreg(3'd2, v);
      chk(v == 4, "R7 period deferred", v, 4);
      wait_evt();
      rreg(3'd2, v);
      chk(v == 6, "R7 period reloaded", v, 6);
      gap(g);
      chk(g == 7, "R7 new period spacing", g, 7);

      // R4 center mode, period 5 -> 10 strobes
      wreg(3'd0, 32'h100); wreg(3'd2, 5); wreg(3'd1, 3);
      @(negedge clk); en = 1'b0;
      @(negedge clk); en = 1'b1;
      gap(g);
      chk(g == 10, "R4 center spacing", g, 10);
      idle(20);

      // R5 idle-high polarity, and R6 disabled
      wreg(3'd0, 32'h200);
      idle(15);
      @(negedge clk); en = 1'b0;
      idle(2); #5;
      rreg(3'd3, v);
      chk(v == 0, "R6 counter zero", v, 0);
      chk(wave == 1'b1, "R6 wave idle high", int'(wave), 1);
      c1 = 0;
      repeat (10) begin @(posedge clk); #5; if (evt) c1++; end
      chk(c1 == 0, "R6 no events", c1, 0);
      @(negedge clk); en = 1'b1;
      @(posedge clk); #5;
      rreg(3'd3, v);
      chk(v == 1, "R6 fresh start", v, 1);

      // R2 sources: prescaler 2, divider A, divider B, then disabled code
      wreg(3'd0, 2); wreg(3'd2, 3); wreg(3'd1, 2);
      gap(g);
      chk(g == 16, "R2 prescale 2", g, 16);
      wreg(3'd0, 11);
      gap(g);
      chk(g == 12, "R2 divider A", g, 12);
      wreg(3'd0, 12);
      gap(g);
      chk(g == 28, "R2 divider B", g, 28);
      wreg(3'd0, 13);
      rreg(3'd3, c1);
      idle(12); #5;
      rreg(3'd3, c2);
      chk(c1 == c2, "R2 code 13 frozen", c2, c1);

      // R9 period zero
      wreg(3'd1, 0); wreg(3'd2, 0); wreg(3'd0, 0);
      idle(2);
      c1 = 0;
      repeat (6) begin @(posedge clk); #5; if (evt && wave == 1'b0) c1++; end
      chk(c1 == 6, "R9 event every strobe, idle wave", c1, 6);

      // mixed run in center mode with reload, model compares per cycle
      wreg(3'd2, 9); wreg(3'd1, 4); wreg(3'd0, 32'h101);
      wreg(3'd4, 7);
      idle(200);
      wreg(3'd0, 32'h003);
      idle(300);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule